// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width-modulated output from a counter that runs on a selectable, prescaled clock enable. Software reaches it over a simple 32-bit register bus. Each bus write of a duty value is placed in a small queue. The counter takes the next queued value as it starts each period. Software can therefore line up several duty changes ahead of time, and every change takes effect on a clean period boundary.

The counter step comes from one of two clock-enable inputs. That enable is divided by a programmable 12-bit divisor. The programmed period is stretched by two counts. Four low-power mode inputs each freeze the counter unless the matching run-permission bit is set. A self-clearing reset bit in the control register puts the whole block back into its power-on state.

The sequencer has four states:
- `S_OFF`: idle. The counter is held at zero and the output is low.
- `S_RUN`: counting.
- `S_HOLD`: frozen by a low-power input. The counter and the output keep their values.
- `S_SWRST`: soft reset in progress.

The transitions are:
- `S_OFF→S_RUN` on enable. This loads the first queued duty.
- `S_RUN→S_HOLD` on freeze, and `S_HOLD→S_RUN` when the freeze drops.
- `S_RUN→S_OFF` and `S_HOLD→S_OFF` when enable drops.
- Any state `→S_SWRST` while the reset bit is busy.
- `S_SWRST→S_OFF` once the reset bit has cleared.

Top module: `pwm_fifo_top`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low. The registers are control at byte offset 0x00, status at 0x04, duty queue at 0x0C and period at 0x10. Reads return data one clock after `bus_rd` is sampled. Reading 0x0C returns the duty value now in use.
- R2: Control bit 0 is the enable. While it is 0, `pwm_out` is low and the counter rests at zero. Writing 0 to the control register stops the output.
- R3: One output period lasts period-register + 2 counter steps. Before inversion, the output is high while the counter (0 … period+1) is below the active duty. A duty of 0 gives a constant low. A duty of period+2 or more gives a constant high.
- R4: Control bits 15:4 hold the divisor minus one. The counter advances once every divisor selected enables, for divisors 1 to 4096.
- R5: Control bits 17:16 select the counter step source: 1 = `bus_ck_en`, 2 = `fast_ck_en`. The values 0 and 3 supply no steps, so the counter stays where it is.
- R6: Control bit 18 inverts the output while the block is enabled.
- R7: Control bits 22, 23, 24 and 25 allow counting during `mode_debug`, `mode_wait`, `mode_doze` and `mode_stop` respectively. When a mode input is high and its bit is 0, the counter and the output freeze.
- R8: Writing to offset 0x0C pushes bits 15:0 into a four-entry queue, and status bits 2:0 give the number of entries held. The oldest entry is taken when the block is enabled and at each period rollover, in write order.
- R9: When the queue is empty at a rollover, the previous duty stays in use.
- R10: A duty write while the queue holds four entries is dropped and sets status bit 3. That bit stays set until 1 is written to status bit 3.
- R11: Writing 1 to control bit 3 starts a soft reset. Bit 3 reads 1 for `RST_CYCLES` clocks and then clears. Meanwhile bus writes are ignored, the queue empties, the output is low, and all registers return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| bus_ck_en | input | 1 | Counter step enable, source 1 |
| fast_ck_en | input | 1 | Counter step enable, source 2 |
| mode_stop | input | 1 | Stop low-power mode active |
| mode_doze | input | 1 | Doze low-power mode active |
| mode_wait | input | 1 | Wait low-power mode active |
| mode_debug | input | 1 | Debug halt active |
| pwm_out | output | 1 | Modulated output |

## Verification
The following properties are checked on every clock:
- A disabled or resetting block keeps `pwm_out` low.
- The soft reset empties the queue.
- A write to a full queue raises the overflow flag.
- An accepted push raises the occupancy by one, and the occupancy never exceeds the depth.
- A pop happens only on a non-empty queue.
- The active duty changes only on a pop or a reset.

Some behaviour can only be shown by the bench scenarios, because it depends on the whole timeline:
- the measured high time and the period length,
- the divisor and source selection,
- inversion,
- freezing under each mode input,
- the order in which queued duties appear,
- the ignored writes during a soft reset.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int CNT_W      = 16;
    localparam int PRESC_W    = 12;
    localparam int FIFO_DEPTH = 4;
    localparam int RST_CYCLES = 8;

    // register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DUTY = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PER  = 5'h10;

    // control field positions
    localparam int CB_EN     = 0;
    localparam int CB_SWR    = 3;
    localparam int CB_PRE_LO = 4;
    localparam int CB_SEL_LO = 16;
    localparam int CB_INV    = 18;
    localparam int CB_RUN_LO = 22;   // debug, wait, doze, stop
    localparam int SB_OVF    = 3;

    localparam logic [1:0] SEL_BUS  = 2'd1;
    localparam logic [1:0] SEL_FAST = 2'd2;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_RUN   = 2'd1,
        S_HOLD  = 2'd2,
        S_SWRST = 2'd3
    } pwm_state_e;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[rd_ptr_q];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (push_ok && !flush && wr_ptr_q == PTR_W'(i))
                mem_q[i] <= push_data;
        end
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               advance,
    input  logic [1:0]         sel,
    input  logic               bus_ck_en,
    input  logic               fast_ck_en,
    input  logic [PRESC_W-1:0] div_m1,
    output logic               tick
);
    import pwm_pkg::*;

    logic [PRESC_W-1:0] pre_q;
    logic               src_en;

    always_comb begin
        unique case (sel)
            SEL_BUS:  src_en = bus_ck_en;
            SEL_FAST: src_en = fast_ck_en;
            default:  src_en = 1'b0;
        endcase
    end

    assign tick = advance && src_en && (pre_q == div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear)
            pre_q <= '0;
        else if (advance && src_en)
            pre_q <= tick ? '0 : pre_q + PRESC_W'(1);
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             srst,
    input  logic             freeze,
    input  logic             tick,
    input  logic             invert,
    input  logic [CNT_W-1:0] period,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_head,
    output logic             pop,
    output logic             advance,
    output logic             presc_clear,
    output logic [CNT_W-1:0] duty_q,
    output logic             pwm_out
);
    import pwm_pkg::*;

    localparam int PC_W = CNT_W + 1;

    pwm_state_e       state_q, state_d;
    logic [PC_W-1:0]  cnt_q;
    logic [PC_W-1:0]  last_cnt;
    logic             rollover, load;

    assign last_cnt = {1'b0, period} + PC_W'(1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (srst)    state_d = S_SWRST;
                else if (en) state_d = S_RUN;
            end
            S_RUN: begin
                if (srst)        state_d = S_SWRST;
                else if (!en)    state_d = S_OFF;
                else if (freeze) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (srst)         state_d = S_SWRST;
                else if (!en)     state_d = S_OFF;
                else if (!freeze) state_d = S_RUN;
            end
            S_SWRST: begin
                if (!srst) state_d = S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    assign advance     = (state_q == S_RUN) && (state_d == S_RUN);
    assign presc_clear = (state_d == S_OFF) || (state_d == S_SWRST);
    assign rollover    = advance && tick && (cnt_q == last_cnt);
    assign load        = ((state_q == S_OFF) && (state_d == S_RUN)) || rollover;
    assign pop         = load && !fifo_empty;

    // period counter and active duty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (state_d == S_SWRST) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (state_d == S_OFF) begin
            cnt_q  <= '0;
        end else if (load) begin
            cnt_q  <= '0;
            if (!fifo_empty) duty_q <= fifo_head;
        end else if (advance && tick) begin
            cnt_q  <= cnt_q + PC_W'(1);
        end
    end

    // output
    always_comb begin
        unique case (state_q)
            S_RUN, S_HOLD: pwm_out = ({1'b0, duty_q} > cnt_q) ^ invert;
            default:       pwm_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int CNT_W      = 16,
    parameter int PRESC_W    = 12,
    parameter int FC_W       = 3,
    parameter int RST_CYCLES = 8,
    localparam int RC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [FC_W-1:0]    fifo_cnt,
    input  logic               fifo_full,
    input  logic [CNT_W-1:0]   duty_q,
    output logic               ctrl_en,
    output logic [PRESC_W-1:0] div_m1,
    output logic [1:0]         clk_sel,
    output logic               invert,
    output logic [3:0]         run_mask,
    output logic [CNT_W-1:0]   period,
    output logic               sample_push,
    output logic [CNT_W-1:0]   sample_data,
    output logic               ovf_flag,
    output logic               swr_busy
);
    import pwm_pkg::*;

    logic [RC_W-1:0] swr_cnt_q;
    logic            wr_ctrl, wr_stat, wr_per;
    logic            unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_ctrl     = bus_wr && !swr_busy && (bus_addr == OFS_CTRL);
    assign wr_stat     = bus_wr && !swr_busy && (bus_addr == OFS_STAT);
    assign wr_per      = bus_wr && !swr_busy && (bus_addr == OFS_PER);
    assign sample_push = bus_wr && !swr_busy && (bus_addr == OFS_DUTY);
    assign sample_data = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            div_m1    <= '0;
            clk_sel   <= '0;
            invert    <= 1'b0;
            run_mask  <= '0;
            period    <= '0;
            ovf_flag  <= 1'b0;
            swr_busy  <= 1'b0;
            swr_cnt_q <= '0;
        end else if (swr_busy) begin
            if (swr_cnt_q == '0) swr_busy  <= 1'b0;
            else                 swr_cnt_q <= swr_cnt_q - RC_W'(1);
        end else begin
            if (sample_push && fifo_full) ovf_flag <= 1'b1;
            if (wr_stat && bus_wdata[SB_OVF]) ovf_flag <= 1'b0;
            if (wr_per) period <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                if (bus_wdata[CB_SWR]) begin
                    ctrl_en   <= 1'b0;
                    div_m1    <= '0;
                    clk_sel   <= '0;
                    invert    <= 1'b0;
                    run_mask  <= '0;
                    period    <= '0;
                    ovf_flag  <= 1'b0;
                    swr_busy  <= 1'b1;
                    swr_cnt_q <= RC_W'(RST_CYCLES - 1);
                end else begin
                    ctrl_en  <= bus_wdata[CB_EN];
                    div_m1   <= bus_wdata[CB_PRE_LO +: PRESC_W];
                    clk_sel  <= bus_wdata[CB_SEL_LO +: 2];
                    invert   <= bus_wdata[CB_INV];
                    run_mask <= bus_wdata[CB_RUN_LO +: 4];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= '0;
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[CB_EN]                <= ctrl_en;
                    bus_rdata[CB_SWR]               <= swr_busy;
                    bus_rdata[CB_PRE_LO +: PRESC_W] <= div_m1;
                    bus_rdata[CB_SEL_LO +: 2]       <= clk_sel;
                    bus_rdata[CB_INV]               <= invert;
                    bus_rdata[CB_RUN_LO +: 4]       <= run_mask;
                end
                OFS_STAT: begin
                    bus_rdata[FC_W-1:0] <= fifo_cnt;
                    bus_rdata[SB_OVF]   <= ovf_flag;
                end
                OFS_DUTY: bus_rdata[CNT_W-1:0] <= duty_q;
                OFS_PER:  bus_rdata[CNT_W-1:0] <= period;
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_fifo_top.sv
module pwm_fifo_top
    import pwm_pkg::*;
#(
    parameter int P_CNT_W      = CNT_W,
    parameter int P_PRESC_W    = PRESC_W,
    parameter int P_DEPTH      = FIFO_DEPTH,
    parameter int P_RST_CYCLES = RST_CYCLES,
    localparam int FC_W = $clog2(P_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ck_en,
    input  logic              fast_ck_en,
    input  logic              mode_stop,
    input  logic              mode_doze,
    input  logic              mode_wait,
    input  logic              mode_debug,
    output logic              pwm_out
);

    logic                 ctrl_en, invert, sample_push, ovf_flag, swr_busy;
    logic [P_PRESC_W-1:0] div_m1;
    logic [1:0]           clk_sel;
    logic [3:0]           run_mask, mode_vec;
    logic [P_CNT_W-1:0]   period, sample_data, duty_q, fifo_head;
    logic [FC_W-1:0]      fifo_cnt;
    logic                 fifo_full, fifo_empty, fifo_pop;
    logic                 tick, advance, presc_clear, freeze;

    assign mode_vec = {mode_stop, mode_doze, mode_wait, mode_debug};
    assign freeze   = |(mode_vec & ~run_mask);

    pwm_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(P_CNT_W),
        .PRESC_W(P_PRESC_W), .FC_W(FC_W), .RST_CYCLES(P_RST_CYCLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .duty_q(duty_q),
        .ctrl_en(ctrl_en), .div_m1(div_m1), .clk_sel(clk_sel),
        .invert(invert), .run_mask(run_mask), .period(period),
        .sample_push(sample_push), .sample_data(sample_data),
        .ovf_flag(ovf_flag), .swr_busy(swr_busy)
    );

    pwm_sample_fifo #(.W(P_CNT_W), .DEPTH(P_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(swr_busy),
        .push(sample_push), .push_data(sample_data), .pop(fifo_pop),
        .head(fifo_head), .count(fifo_cnt), .full(fifo_full),
        .empty(fifo_empty)
    );

    pwm_prescaler #(.PRESC_W(P_PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(presc_clear), .advance(advance),
        .sel(clk_sel), .bus_ck_en(bus_ck_en), .fast_ck_en(fast_ck_en),
        .div_m1(div_m1), .tick(tick)
    );

    pwm_core #(.CNT_W(P_CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .srst(swr_busy),
        .freeze(freeze), .tick(tick), .invert(invert), .period(period),
        .fifo_empty(fifo_empty), .fifo_head(fifo_head), .pop(fifo_pop),
        .advance(advance), .presc_clear(presc_clear), .duty_q(duty_q),
        .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_fifo_checker.sv
module pwm_fifo_checker #(
    parameter int DEPTH = 4,
    parameter int FC_W  = 3,
    parameter int W     = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwm_out,
    input logic            ctrl_en,
    input logic            swr_busy,
    input logic            sample_push,
    input logic            fifo_full,
    input logic            fifo_pop,
    input logic [FC_W-1:0] fifo_cnt,
    input logic            ovf_flag,
    input logic [W-1:0]    duty_q
);

    // R2: disabled for two clocks means a low output
    a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && $past(!ctrl_en)) |-> !pwm_out);

    // R11: an ongoing soft reset keeps the output low and the queue empty
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (swr_busy && $past(swr_busy)) |-> (!pwm_out && fifo_cnt == '0));

    // R10: a write into a full queue raises the overflow flag
    a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_push && fifo_full) |=> ovf_flag);

    // R8: occupancy bound
    a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FC_W'(DEPTH));

    // R8: accepted push without pop adds one entry
    a_r8_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_push && !fifo_full && !fifo_pop) |=> fifo_cnt == $past(fifo_cnt) + FC_W'(1));

    // R8: pops only from a non-empty queue
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_cnt != '0);

    // R9: the active duty moves only on a pop
    a_r9_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_pop && !swr_busy) |=> $stable(duty_q));

endmodule

bind pwm_fifo_top pwm_fifo_checker #(
    .DEPTH(P_DEPTH), .FC_W(FC_W), .W(P_CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .ctrl_en(ctrl_en),
    .swr_busy(swr_busy), .sample_push(sample_push), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_cnt(fifo_cnt), .ovf_flag(ovf_flag),
    .duty_q(duty_q)
);

// File: tb/pwm_fifo_top_tb_top.sv
`timescale 1ns/1ps
module pwm_fifo_top_tb_top;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_DUTY = 5'h0C;
    localparam logic [4:0] A_PER  = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ck_en = 1'b1, fast_ck_en = 1'b0;
    logic [3:0]  modes = '0;   // {stop, doze, wait, debug}
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwm_fifo_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ck_en(bus_ck_en), .fast_ck_en(fast_ck_en),
        .mode_stop(modes[3]), .mode_doze(modes[2]), .mode_wait(modes[1]),
        .mode_debug(modes[0]), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit en, input int div, input int sel,
                                            input bit inv, input logic [3:0] run);
        logic [31:0] c;
        c = '0;
        c[0] = en;
        c[15:4] = 12'(div - 1);
        c[17:16] = 2'(sel);
        c[18] = inv;
        c[25:22] = run;
        return c;
    endfunction

    function automatic int exp_high(input int p, input int d, input int div, input bit inv);
        int hi;
        hi = (d > p + 2) ? p + 2 : d;
        if (inv) hi = p + 2 - hi;
        return hi * div;
    endfunction

    // watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int h, len, t, p, d, dv, seed;
        bit iv;

        seed = $urandom(32'd20240611);
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        rd(A_CTRL, r); check(r == 0, "R1 ctrl", r, 0);
        rd(A_STAT, r); check(r == 0, "R1 status", r, 0);
        rd(A_DUTY, r); check(r == 0, "R1 duty", r, 0);
        rd(A_PER,  r); check(r == 0, "R1 period", r, 0);
        check(pwm_out == 0, "R1 output", pwm_out, 0);

        // R3 basic waveform, period 18 -> 20 steps
        wr(A_DUTY, 7);
        wr(A_PER, 18);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
        wait_n(6);
        count_high(20, h); check(h == 7, "R3 high in one period", h, 7);
        count_high(60, h); check(h == 21, "R3 high in three periods", h, 21);
        t = 0;
        while (pwm_out && t < 100) begin @(negedge clk); t++; end
        while (!pwm_out && t < 200) begin @(negedge clk); t++; end
        len = 0;
        do begin @(negedge clk); len++; end while (pwm_out && len < 100);
        do begin @(negedge clk); len++; end while (!pwm_out && len < 100);
        check(len == 20, "R3 period length", len, 20);

        // R3 duty extremes, taken at next rollover
        wr(A_DUTY, 0);
        wait_n(25);
        count_high(20, h); check(h == 0, "R3 zero duty", h, 0);
        wr(A_DUTY, 25);
        wait_n(25);
        count_high(20, h); check(h == 20, "R3 duty above period", h, 20);

        // R2 disable
        wr(A_CTRL, 0);
        wait_n(2);
        count_high(30, h); check(h == 0, "R2 disabled output low", h, 0);

        // R8 / R9 queue order
        wr(A_DUTY, 11); wr(A_DUTY, 22); wr(A_DUTY, 33);
        rd(A_STAT, r); check(r[2:0] == 3, "R8 occupancy three", r[2:0], 3);
        wr(A_PER, 60);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
        wait_n(5);
        rd(A_DUTY, r); check(r == 11, "R8 first entry", r, 11);
        rd(A_STAT, r); check(r[2:0] == 2, "R8 occupancy after pop", r[2:0], 2);
        wait_n(62);
        rd(A_DUTY, r); check(r == 22, "R8 second entry", r, 22);
        wait_n(62);
        rd(A_DUTY, r); check(r == 33, "R8 third entry", r, 33);
        rd(A_STAT, r); check(r[2:0] == 0, "R8 queue drained", r[2:0], 0);
        wait_n(130);
        rd(A_DUTY, r); check(r == 33, "R9 duty kept when empty", r, 33);

        // R10 overflow
        wr(A_CTRL, 0);
        for (int i = 1; i <= 5; i++) wr(A_DUTY, 32'(i * 10));
        rd(A_STAT, r); check(r[3:0] == 4'hC, "R10 full and overflow", r[3:0], 12);
        wr(A_STAT, 0);
        rd(A_STAT, r); check(r[3] == 1, "R10 flag sticky", r[3], 1);
        wr(A_STAT, 32'h8);
        rd(A_STAT, r); check(r[3:0] == 4'h4, "R10 flag cleared", r[3:0], 4);
        wr(A_PER, 4);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
        wait_n(3);
        rd(A_DUTY, r); check(r == 10, "R10 oldest kept", r, 10);
        wait_n(30);
        rd(A_DUTY, r); check(r == 40, "R10 fifth write dropped", r, 40);

        // R11 soft reset
        wr(A_DUTY, 3);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, r); check(r[3] == 1, "R11 busy reads one", r[3], 1);
        wr(A_PER, 32'h55);
        wr(A_DUTY, 32'h9);
        wait_n(12);
        rd(A_CTRL, r); check(r == 0, "R11 ctrl cleared", r, 0);
        rd(A_PER,  r); check(r == 0, "R11 period cleared, write ignored", r, 0);
        rd(A_STAT, r); check(r == 0, "R11 queue flushed", r, 0);
        rd(A_DUTY, r); check(r == 0, "R11 duty cleared", r, 0);
        check(pwm_out == 0, "R11 output low", pwm_out, 0);

        // R4 prescaler
        wr(A_DUTY, 3); wr(A_PER, 8);
        wr(A_CTRL, mk_ctrl(1, 3, 1, 0, 4'h0));
        wait_n(10);
        count_high(30, h); check(h == 9, "R4 divide by 3", h, 9);
        wr(A_CTRL, 0);
        wr(A_DUTY, 1); wr(A_PER, 0);
        wr(A_CTRL, mk_ctrl(1, 4096, 1, 0, 4'h0));
        wait_n(4);
        count_high(8192, h); check(h == 4096, "R4 divide by 4096", h, 4096);

        // R5 source select
        wr(A_CTRL, 0);
        wr(A_DUTY, 3); wr(A_PER, 8);
        bus_ck_en = 1'b0; fast_ck_en = 1'b1;
        wr(A_CTRL, mk_ctrl(1, 1, 2, 0, 4'h0));
        wait_n(4);
        count_high(30, h); check(h == 9, "R5 fast source", h, 9);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
        wait_n(4);
        count_high(30, h); check(h == 0, "R5 bus source idle", h, 0);
        bus_ck_en = 1'b1; fast_ck_en = 1'b0;
        wr(A_CTRL, 0);
        wr(A_CTRL, mk_ctrl(1, 1, 0, 0, 4'h0));
        wait_n(4);
        count_high(30, h); check(h == 30, "R5 no source stays at zero", h, 30);

        // R6 inversion
        wr(A_CTRL, mk_ctrl(1, 1, 1, 1, 4'h0));
        wait_n(4);
        count_high(30, h); check(h == 21, "R6 inverted", h, 21);

        // R7 low-power freeze and run permission
        wr(A_CTRL, 0);
        wr(A_DUTY, 9); wr(A_PER, 18);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
        wait_n(4);
        for (int i = 0; i < 4; i++) begin
            wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'h0));
            modes = 4'(1 << i);
            wait_n(3);
            count_high(40, h);
            check(h == 0 || h == 40, "R7 frozen under mode", h, 0);
            modes = '0;
            wait_n(2);
            count_high(20, h); check(h == 9, "R7 resumes", h, 9);
            wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 4'(1 << i)));
            modes = 4'(1 << i);
            wait_n(2);
            count_high(20, h); check(h == 9, "R7 runs when permitted", h, 9);
            modes = '0;
        end

        // R3 / R4 / R6 random configurations
        for (int k = 0; k < 20; k++) begin
            p  = 2 + int'($urandom % 30);
            d  = int'($urandom % (p + 4));
            dv = 1 + int'($urandom % 3);
            iv = 1'($urandom % 2);
            wr(A_CTRL, 0);
            wr(A_DUTY, 32'(d));
            wr(A_PER, 32'(p));
            wr(A_CTRL, mk_ctrl(1, dv, 1, iv, 4'h0));
            wait_n(4);
            count_high((p + 2) * dv, h);
            check(h == exp_high(p, d, dv, iv), "R3 R4 R6 random", h, exp_high(p, d, dv, iv));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule